// File: doc/BRIEF.md
# Bus-Master Read Address Counter

This block holds the 32-bit memory address that a bus-master read engine uses while it pulls data from the host bus into a local-side FIFO. Local software loads the starting address through a small register port. The port decodes one register offset, and it works only while local bus mastering is enabled. Once a transfer starts, every completed DWORD data phase moves the address on by four bytes. The address therefore always names the next location that has not yet been read, and software may read it at any time to follow progress.

A byte counter inside the block tracks the remaining length, which may be any non-zero number of bytes. The byte counter marks the final data phase, ends the transfer and produces active-low byte enables for a trailing partial DWORD. The address presented in the bus address phase always has its two low bits clear. This marks a linear burst from a burst-capable master.

Control is a three-state machine. IDLE waits for a start. XFER counts data phases. DONE lasts one cycle and signals completion. The named transitions are *start* (IDLE to XFER, on `xfer_start` with a non-zero length), *last_phase* (XFER to DONE, on a data phase with four or fewer bytes remaining) and *retire* (DONE to IDLE, unconditional). A start with zero length keeps the machine in IDLE.

Top module: `bm_rdaddr_ctr`

## Requirements
- R1: After reset the address is 00000000h, `busy` and `done` are low and `byte_en_n` is 1111b.
- R2: A register write is enabled when `master_en` is 1 and `reg_addr` equals 30h. It loads bits 31:2 from `reg_wdata`, and the address reads back with bits 1:0 equal to zero.
- R3: While `master_en` is 0, writes are dropped and `reg_rdata` returns zero. When enabled, `reg_rdata` shows the live address.
- R4: `xfer_start` in IDLE with a non-zero `xfer_bytes` enters XFER, where `busy` is 1. A start with zero length is ignored.
- R5: Each `phase_done` in XFER adds 4 to the address. The new value is visible on `reg_rdata` on the cycle after the phase.
- R6: `bus_addr` always equals the current address with bits 1:0 zero.
- R7: Each data phase reduces the remaining count by 4, or to zero when 4 or fewer bytes remain. The phase that reaches zero moves to DONE. `done` is high for exactly one cycle, and then the machine returns to IDLE.
- R8: In XFER, `byte_en_n` is 0000b while 4 or more bytes remain. With 3, 2 or 1 bytes remaining it is 1000b, 1100b or 1110b (lane 0 is bit 0, low means active). Outside XFER it is 1111b.
- R9: An advance from FFFFFFFCh gives 00000000h, and `wrap` is high for the one cycle after that advance.
- R10: If an enabled register write and a data-phase advance fall in the same cycle, the written value is loaded and the advance is lost. The byte count still decrements.
- R11: `phase_done` outside XFER leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Local bus mastering enabled; gates register access |
| reg_addr | input | 8 | Register port offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (live address or zero) |
| xfer_start | input | 1 | Start a transfer |
| xfer_bytes | input | 16 | Byte length of the transfer |
| phase_done | input | 1 | One DWORD data phase completed |
| bus_addr | output | 32 | Address-phase value for the bus |
| byte_en_n | output | 4 | Active-low byte lane enables |
| busy | output | 1 | Machine is in XFER |
| done | output | 1 | One-cycle transfer completion pulse |
| wrap | output | 1 | One-cycle address wrap flag |

## Verification
Address errors show on `reg_rdata` and `bus_addr` one cycle after the phase or write that caused them. A wrong step size or a lost collision rule therefore surfaces at the next sample. A corrupt byte counter shows first in the `byte_en_n` pattern during the last phases. After that it appears as `done` firing one phase early or late. Wrap errors are visible on the same cycle as the zero address.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } bmr_state_t;
endpackage

// File: rtl/bmr_addr_cnt.sv
module bmr_addr_cnt #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          wrap
);
    localparam int CW = AW - 2;

    logic [CW-1:0] dw_q;
    logic [CW-1:0] dw_nxt;
    logic          carry;

    assign {carry, dw_nxt} = {1'b0, dw_q} + {{CW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_q <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (load) begin
                dw_q <= load_val[AW-1:2];
            end else if (step) begin
                dw_q <= dw_nxt;
                wrap <= carry;
            end
        end
    end

    assign addr = {dw_q, 2'b00};
endmodule

// File: rtl/bmr_byte_cnt.sv
module bmr_byte_cnt #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          active,
    input  logic          step,
    output logic          last,
    output logic [3:0]    be_n
);
    localparam logic [LW-1:0] DW_BYTES = LW'(4);

    logic [LW-1:0] rem_q;
    logic          tail;

    assign tail = (rem_q <= DW_BYTES);
    assign last = active && step && tail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= len;
        end else if (active && step) begin
            rem_q <= tail ? '0 : rem_q - DW_BYTES;
        end
    end

    always_comb begin
        be_n = 4'b1111;
        if (active) begin
            if (rem_q >= DW_BYTES) begin
                be_n = 4'b0000;
            end else begin
                for (int i = 0; i < 4; i++) begin
                    be_n[i] = !(LW'(i) < rem_q);
                end
            end
        end
    end
endmodule

// File: rtl/bmr_fsm.sv
module bmr_fsm
    import bmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       last,
    output bmr_state_t state,
    output logic       busy,
    output logic       done
);
    bmr_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_ok) nxt = ST_XFER;
            ST_XFER: if (last)     nxt = ST_DONE;
            ST_DONE:               nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bm_rdaddr_ctr.sv
module bm_rdaddr_ctr
    import bmr_pkg::*;
#(
    parameter int         AW       = 32,
    parameter int         LW       = 16,
    parameter int         OFW      = 8,
    parameter logic [7:0] REG_OFFS = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic [OFW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          xfer_start,
    input  logic [LW-1:0] xfer_bytes,
    input  logic          phase_done,
    output logic [AW-1:0] bus_addr,
    output logic [3:0]    byte_en_n,
    output logic          busy,
    output logic          done,
    output logic          wrap
);
    bmr_state_t    state;
    logic          wr_hit;
    logic          start_ok;
    logic          last;
    logic          in_xfer;
    logic [AW-1:0] cur_addr;

    assign wr_hit   = master_en && reg_wr && (reg_addr == OFW'(REG_OFFS));
    assign in_xfer  = (state == ST_XFER);
    assign start_ok = (state == ST_IDLE) && xfer_start && (xfer_bytes != '0);

    bmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .last     (last),
        .state    (state),
        .busy     (busy),
        .done     (done)
    );

    bmr_addr_cnt #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_hit),
        .load_val (reg_wdata),
        .step     (in_xfer && phase_done),
        .addr     (cur_addr),
        .wrap     (wrap)
    );

    bmr_byte_cnt #(.LW(LW)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .len      (xfer_bytes),
        .active   (in_xfer),
        .step     (phase_done),
        .last     (last),
        .be_n     (byte_en_n)
    );

    assign bus_addr  = cur_addr;
    assign reg_rdata = master_en ? cur_addr : '0;
endmodule

// File: rtl/bm_rdaddr_ctr_chk.sv
module bm_rdaddr_ctr_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_en,
    input logic [7:0]    reg_addr,
    input logic          reg_wr,
    input logic [AW-1:0] reg_rdata,
    input logic          phase_done,
    input logic [AW-1:0] bus_addr,
    input logic [3:0]    byte_en_n,
    input logic          busy,
    input logic          done,
    input logic          wrap
);
    logic wr_any;
    assign wr_any = master_en && reg_wr && (reg_addr == 8'h30);

    // R2
    rd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1:0] == 2'b00);

    // R3
    rd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> reg_rdata == '0);

    // R6
    bus_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1:0] == 2'b00);

    // R5
    step_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_done && !wr_any) |=> bus_addr == $past(bus_addr) + AW'(4));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> bus_addr == '0);

    // R7
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> byte_en_n == 4'b1111);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_any) |=> $stable(bus_addr));
endmodule

bind bm_rdaddr_ctr bm_rdaddr_ctr_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .phase_done (phase_done),
    .bus_addr   (bus_addr),
    .byte_en_n  (byte_en_n),
    .busy       (busy),
    .done       (done),
    .wrap       (wrap)
);

// File: tb/bm_rdaddr_ctr_test.sv
module bm_rdaddr_ctr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic [7:0]  reg_addr = 8'h30;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_start = 1'b0;
    logic [15:0] xfer_bytes = '0;
    logic        phase_done = 1'b0;
    logic [31:0] bus_addr;
    logic [3:0]  byte_en_n;
    logic        busy, done, wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bm_rdaddr_ctr uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_start(xfer_start), .xfer_bytes(xfer_bytes), .phase_done(phase_done),
        .bus_addr(bus_addr), .byte_en_n(byte_en_n), .busy(busy), .done(done), .wrap(wrap)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [31:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic start(logic [15:0] n);
        xfer_start = 1'b1; xfer_bytes = n;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic phase();
        phase_done = 1'b1;
        tick();
        phase_done = 1'b0;
    endtask

    task automatic t_reset();
        master_en = 1'b1;
        #1;
        chk("R1 addr", reg_rdata, 32'h0);
        chk("R1 be_n", {28'h0, byte_en_n}, 32'hF);
        chk("R1 busy/done", {30'h0, busy, done}, 32'h0);
    endtask

    task automatic t_write();
        wr_reg(32'h1234_5677);
        chk("R2 readback", reg_rdata, 32'h1234_5674);
        chk("R6 bus_addr", bus_addr, 32'h1234_5674);
        reg_addr = 8'h34;
        wr_reg(32'h5555_0000);
        reg_addr = 8'h30;
        chk("R2 other offset", reg_rdata, 32'h1234_5674);
    endtask

    task automatic t_disabled();
        master_en = 1'b0;
        wr_reg(32'hAAAA_0000);
        chk("R3 read gated", reg_rdata, 32'h0);
        master_en = 1'b1;
        #1;
        chk("R3 write dropped", reg_rdata, 32'h1234_5674);
    endtask

    task automatic t_xfer();
        wr_reg(32'h0000_0100);
        phase();
        chk("R11 idle phase", reg_rdata, 32'h100);
        start(16'd0);
        chk("R4 zero length", {31'h0, busy}, 32'h0);
        start(16'd10);
        chk("R4 busy", {31'h0, busy}, 32'h1);
        chk("R8 full", {28'h0, byte_en_n}, 32'h0);
        phase();
        chk("R5 step1", reg_rdata, 32'h104);
        chk("R8 rem6", {28'h0, byte_en_n}, 32'h0);
        phase();
        chk("R5 step2", reg_rdata, 32'h108);
        chk("R8 rem2", {28'h0, byte_en_n}, 32'hC);
        phase();
        chk("R7 done", {30'h0, busy, done}, 32'h1);
        chk("R5 step3", bus_addr, 32'h10C);
        chk("R8 after", {28'h0, byte_en_n}, 32'hF);
        phase();
        chk("R7 retire", {30'h0, busy, done}, 32'h0);
        chk("R11 done phase", bus_addr, 32'h10C);
    endtask

    task automatic t_partial();
        start(16'd3);
        chk("R8 rem3", {28'h0, byte_en_n}, 32'h8);
        phase();
        chk("R7 len3 done", {30'h0, busy, done}, 32'h1);
        tick();
        start(16'd1);
        chk("R8 rem1", {28'h0, byte_en_n}, 32'hE);
        phase();
        chk("R7 len1 done", {30'h0, busy, done}, 32'h1);
        chk("R5 len1 addr", bus_addr, 32'h114);
        tick();
    endtask

    task automatic t_wrap();
        wr_reg(32'hFFFF_FFFC);
        start(16'd8);
        chk("R9 no wrap yet", {31'h0, wrap}, 32'h0);
        phase();
        chk("R9 wrapped addr", reg_rdata, 32'h0);
        chk("R9 wrap flag", {31'h0, wrap}, 32'h1);
        phase();
        chk("R9 flag clears", {31'h0, wrap}, 32'h0);
        chk("R9 after wrap", reg_rdata, 32'h4);
        tick();
    endtask

    task automatic t_collide();
        wr_reg(32'h0000_0200);
        start(16'd8);
        reg_wr = 1'b1; reg_wdata = 32'h0000_0300; phase_done = 1'b1;
        tick();
        reg_wr = 1'b0; phase_done = 1'b0;
        chk("R10 write wins", reg_rdata, 32'h300);
        chk("R10 count still busy", {31'h0, busy}, 32'h1);
        phase();
        chk("R10 count decremented", {30'h0, busy, done}, 32'h1);
        chk("R10 next step", reg_rdata, 32'h304);
        tick();
    endtask

    initial begin
        #1;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_disabled();
        t_xfer();
        t_partial();
        t_wrap();
        t_collide();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule